// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This block sits between the byte shift engine of an SPI controller and its register interface. It holds one transmit byte queue, filled by the host side and drained by the engine, and one receive byte queue, filled by the engine and drained by the host side. Each queue is 64 or 128 bytes deep, set by a parameter. The block also holds a control word and two sets of interrupt flags. The control word sets the two trigger thresholds and can empty either queue in one write. One set of flags tracks interrupt conditions and the other gates them onto a single interrupt line.

Four interrupt sources exist. The receive-ready source is a level condition: the receive queue holds at least its threshold. The transmit-request source is also a level condition: the transmit queue holds no more than its threshold. The receive-overflow source is an event raised by an engine push into a full receive queue. The transfer-complete source is an event raised by a strobe from the engine. A pending flag is cleared by writing a one to its position. A level source whose condition still holds comes back one cycle after it is cleared, so software can clear it only after it has served the queue.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue returns bytes in the order they were pushed. The receive byte at the head is visible on `host_rx_data` and the transmit byte at the head is visible on `eng_tx_data` before they are popped. `fifo_sta_rdata` gives the receive occupancy at bit 0 upward and the transmit occupancy at bit 16 upward.
- R2: A push into a full transmit queue is dropped and `host_tx_full` stays high. A pop from an empty queue leaves its occupancy at 0 and does not disturb later ordering.
- R3: An engine push into a full receive queue drops the byte, leaves the occupancy at DEPTH, and sets the overflow flag (bit 8) at that same clock edge.
- R4: The receive-ready flag (bit 0) becomes set one cycle after the receive occupancy is at or above the 8-bit receive threshold held in control bits [7:0]. This includes threshold 0 and threshold DEPTH.
- R5: The transmit-request flag (bit 4) becomes set one cycle after the transmit occupancy is at or below the 8-bit transmit threshold held in control bits [23:16].
- R6: A one-cycle `eng_xfer_done` strobe sets the transfer-complete flag (bit 12) at the next clock edge.
- R7: Writing `int_sta_wdata` with `int_sta_we` clears each flag whose bit is 1 and leaves flags written with 0 unchanged. For a level source the clear takes effect at that edge, and the flag returns one cycle later if its condition still holds. A source event in the same cycle as a clear keeps its flag set.
- R8: Writing control with bit 15 set empties the receive queue at that edge, and bit 31 does the same for the transmit queue. Both bits read back as 0.
- R9: After reset both thresholds read back as 3/4 of DEPTH, the queues are empty, the enables are 0, and no flag is set before the first clock edge after reset.
- R10: `irq` is high when any flag is set while its enable is set. Enable bits use the same positions as the flags (0, 4, 8, 12) and read back through `int_en_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_xfer_done | input | 1 | Transfer-complete strobe |
| host_tx_push | input | 1 | Host writes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from the host |
| host_tx_full | output | 1 | Transmit queue full |
| host_rx_pop | input | 1 | Host takes the head receive byte |
| host_rx_data | output | 8 | Head receive byte |
| host_rx_empty | output | 1 | Receive queue empty |
| fifo_ctl_we | input | 1 | Control word write strobe |
| fifo_ctl_wdata | input | 32 | Control word write data |
| fifo_ctl_rdata | output | 32 | Control word readback |
| fifo_sta_rdata | output | 32 | Occupancy readback |
| int_en_we | input | 1 | Enable mask write strobe |
| int_en_wdata | input | 32 | Enable mask write data |
| int_en_rdata | output | 32 | Enable mask readback |
| int_sta_we | input | 1 | Write-one-to-clear strobe for the flags |
| int_sta_wdata | input | 32 | Clear mask |
| int_sta_rdata | output | 32 | Pending flags |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the push, pop, strobe and write inputs are sampled only at rising clock edges and are stable around them, and that `eng_xfer_done` is a pulse rather than a held level. The bench drives every input just after a falling edge and holds each strobe for exactly one cycle. The overflow assertion assumes that an overflow flag can only appear after a rejected push. The stimulus therefore clears that flag explicitly before it fills the receive queue to its limit.

// File: rtl/spi_fiu_pkg.sv
package spi_fiu_pkg;

   localparam int NUM_SRC    = 4;
   localparam int SRC_STRIDE = 4;   // flag i lives at bit i*SRC_STRIDE

   typedef enum logic [1:0] {
      SRC_RX_READY  = 2'd0,
      SRC_TX_REQ    = 2'd1,
      SRC_RX_OVF    = 2'd2,
      SRC_XFER_DONE = 2'd3
   } irq_src_e;

   // level-derived sources get clear-wins behaviour, events get set-wins
   localparam logic [NUM_SRC-1:0] SRC_IS_LEVEL = 4'b0011;

   localparam int LVL_W        = 8;
   localparam int RX_LVL_LSB   = 0;
   localparam int TX_LVL_LSB   = 16;
   localparam int RX_FLUSH_BIT = 15;
   localparam int TX_FLUSH_BIT = 31;
   localparam int RX_CNT_LSB   = 0;
   localparam int TX_CNT_LSB   = 16;

   function automatic logic [31:0] spread_flags(input logic [NUM_SRC-1:0] v);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < NUM_SRC; i++) r[i*SRC_STRIDE] = v[i];
      return r;
   endfunction

   function automatic logic [NUM_SRC-1:0] gather_flags(input logic [31:0] w);
      logic [NUM_SRC-1:0] r;
      for (int i = 0; i < NUM_SRC; i++) r[i] = w[i*SRC_STRIDE];
      return r;
   endfunction

endpackage

// File: rtl/spi_fiu_byte_fifo.sv
module spi_fiu_byte_fifo #(
   parameter int DEPTH  = 128,
   parameter int DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   output logic              drop
);

   if ((1 << PTR_W) != DEPTH) begin : g_depth_chk
      $error("spi_fiu_byte_fifo: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              wr_en, rd_en;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign wr_en = push & ~full & ~flush;
   assign rd_en = pop & ~empty & ~flush;
   assign drop  = push & full & ~flush;

   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !full && !flush) |=> (count == $past(count) + 1'b1));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

endmodule

// File: rtl/spi_fiu_level_cmp.sv
module spi_fiu_level_cmp #(
   parameter int CNT_W       = 8,
   parameter int LVL_W       = 8,
   parameter bit AT_OR_ABOVE = 1'b1,
   localparam int CMP_W      = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
   input  logic [CNT_W-1:0] count,
   input  logic [LVL_W-1:0] level,
   output logic             hit
);

   logic [CMP_W-1:0] cnt_x, lvl_x;

   assign cnt_x = CMP_W'(count);
   assign lvl_x = CMP_W'(level);

   if (AT_OR_ABOVE) begin : g_above
      assign hit = (cnt_x >= lvl_x);
   end else begin : g_below
      assign hit = (cnt_x <= lvl_x);
   end

endmodule

// File: rtl/spi_fiu_irq_status.sv
module spi_fiu_irq_status #(
   parameter int                 NUM_SRC  = 4,
   parameter logic [NUM_SRC-1:0] IS_LEVEL = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] cond,
   input  logic [NUM_SRC-1:0] clr,
   input  logic [NUM_SRC-1:0] en,
   output logic [NUM_SRC-1:0] flags,
   output logic               irq
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (IS_LEVEL[i]) begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (clr[i]) flags[i] <= 1'b0;
            else if (cond[i]) flags[i] <= 1'b1;
         end

         assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !flags[i]);

         assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cond[i] && !clr[i]) |=> flags[i]);
      end else begin : g_event
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (cond[i]) flags[i] <= 1'b1;
            else if (clr[i])  flags[i] <= 1'b0;
         end

         assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> flags[i]);
      end
   end

   assign irq = |(flags & en);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
   import spi_fiu_pkg::*;
#(
   parameter int DEPTH     = 128,
   parameter int RESET_LVL = DEPTH / 4 * 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        eng_tx_pop,
   output logic [7:0]  eng_tx_data,
   output logic        eng_tx_empty,
   input  logic        eng_rx_push,
   input  logic [7:0]  eng_rx_data,
   input  logic        eng_xfer_done,
   input  logic        host_tx_push,
   input  logic [7:0]  host_tx_data,
   output logic        host_tx_full,
   input  logic        host_rx_pop,
   output logic [7:0]  host_rx_data,
   output logic        host_rx_empty,
   input  logic        fifo_ctl_we,
   input  logic [31:0] fifo_ctl_wdata,
   output logic [31:0] fifo_ctl_rdata,
   output logic [31:0] fifo_sta_rdata,
   input  logic        int_en_we,
   input  logic [31:0] int_en_wdata,
   output logic [31:0] int_en_rdata,
   input  logic        int_sta_we,
   input  logic [31:0] int_sta_wdata,
   output logic [31:0] int_sta_rdata,
   output logic        irq
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (!(DEPTH == 64 || DEPTH == 128)) begin : g_depth_chk
      $error("spi_fifo_irq_unit: DEPTH must be 64 or 128");
   end
   if (RESET_LVL < 0 || RESET_LVL > DEPTH) begin : g_lvl_chk
      $error("spi_fifo_irq_unit: RESET_LVL out of range");
   end

   logic [LVL_W-1:0]   rx_lvl_q, tx_lvl_q;
   logic [NUM_SRC-1:0] en_q, flags, cond, clr;
   logic               flush_rx, flush_tx;
   logic [CNT_W-1:0]   rx_cnt, tx_cnt;
   logic               rx_full, tx_empty, rx_empty, tx_full;
   logic               rx_drop, tx_drop, rx_hit, tx_hit;
   logic               unused_bits;

   assign unused_bits = ^{fifo_ctl_wdata[14:8], fifo_ctl_wdata[30:24], tx_drop};

   // control word: thresholds plus self-clearing flush strobes
   assign flush_rx = fifo_ctl_we & fifo_ctl_wdata[RX_FLUSH_BIT];
   assign flush_tx = fifo_ctl_we & fifo_ctl_wdata[TX_FLUSH_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl_q <= LVL_W'(RESET_LVL);
         tx_lvl_q <= LVL_W'(RESET_LVL);
      end else if (fifo_ctl_we) begin
         rx_lvl_q <= fifo_ctl_wdata[RX_LVL_LSB +: LVL_W];
         tx_lvl_q <= fifo_ctl_wdata[TX_LVL_LSB +: LVL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (int_en_we) en_q <= gather_flags(int_en_wdata);
   end

   spi_fiu_byte_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_tx),
      .push      (host_tx_push),
      .push_data (host_tx_data),
      .pop       (eng_tx_pop),
      .pop_data  (eng_tx_data),
      .count     (tx_cnt),
      .full      (tx_full),
      .empty     (tx_empty),
      .drop      (tx_drop)
   );

   spi_fiu_byte_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_rx),
      .push      (eng_rx_push),
      .push_data (eng_rx_data),
      .pop       (host_rx_pop),
      .pop_data  (host_rx_data),
      .count     (rx_cnt),
      .full      (rx_full),
      .empty     (rx_empty),
      .drop      (rx_drop)
   );

   spi_fiu_level_cmp #(.CNT_W(CNT_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)) u_rx_cmp (
      .count (rx_cnt),
      .level (rx_lvl_q),
      .hit   (rx_hit)
   );

   spi_fiu_level_cmp #(.CNT_W(CNT_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)) u_tx_cmp (
      .count (tx_cnt),
      .level (tx_lvl_q),
      .hit   (tx_hit)
   );

   always_comb begin
      cond                = '0;
      cond[SRC_RX_READY]  = rx_hit;
      cond[SRC_TX_REQ]    = tx_hit;
      cond[SRC_RX_OVF]    = rx_drop;
      cond[SRC_XFER_DONE] = eng_xfer_done;
   end

   assign clr = int_sta_we ? gather_flags(int_sta_wdata) : '0;

   spi_fiu_irq_status #(.NUM_SRC(NUM_SRC), .IS_LEVEL(SRC_IS_LEVEL)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond),
      .clr   (clr),
      .en    (en_q),
      .flags (flags),
      .irq   (irq)
   );

   assign eng_tx_empty  = tx_empty;
   assign host_tx_full  = tx_full;
   assign host_rx_empty = rx_empty;

   always_comb begin
      fifo_ctl_rdata                            = '0;
      fifo_ctl_rdata[RX_LVL_LSB +: LVL_W]       = rx_lvl_q;
      fifo_ctl_rdata[TX_LVL_LSB +: LVL_W]       = tx_lvl_q;
      fifo_sta_rdata                            = '0;
      fifo_sta_rdata[RX_CNT_LSB +: CNT_W]       = rx_cnt;
      fifo_sta_rdata[TX_CNT_LSB +: CNT_W]       = tx_cnt;
   end

   assign int_en_rdata  = spread_flags(en_q);
   assign int_sta_rdata = spread_flags(flags);

   assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[SRC_RX_OVF]) |-> $past(eng_rx_push && rx_full));

   assert_flush_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ctl_rdata[RX_FLUSH_BIT] == 1'b0) && (fifo_ctl_rdata[TX_FLUSH_BIT] == 1'b0));

endmodule

// File: tb/spi_fifo_irq_unit_tb_top.sv
module spi_fifo_irq_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_xfer_done = 1'b0;
   logic [7:0]  eng_rx_data = '0, host_tx_data = '0;
   logic        host_tx_push = 1'b0, host_rx_pop = 1'b0;
   logic        fifo_ctl_we = 1'b0, int_en_we = 1'b0, int_sta_we = 1'b0;
   logic [31:0] fifo_ctl_wdata = '0, int_en_wdata = '0, int_sta_wdata = '0;
   logic [7:0]  eng_tx_data, host_rx_data;
   logic        eng_tx_empty, host_tx_full, host_rx_empty, irq;
   logic [31:0] fifo_ctl_rdata, fifo_sta_rdata, int_en_rdata, int_sta_rdata;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   spi_fifo_irq_unit #(.DEPTH(128)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_xfer_done(eng_xfer_done),
      .host_tx_push(host_tx_push), .host_tx_data(host_tx_data), .host_tx_full(host_tx_full),
      .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data), .host_rx_empty(host_rx_empty),
      .fifo_ctl_we(fifo_ctl_we), .fifo_ctl_wdata(fifo_ctl_wdata), .fifo_ctl_rdata(fifo_ctl_rdata),
      .fifo_sta_rdata(fifo_sta_rdata),
      .int_en_we(int_en_we), .int_en_wdata(int_en_wdata), .int_en_rdata(int_en_rdata),
      .int_sta_we(int_sta_we), .int_sta_wdata(int_sta_wdata), .int_sta_rdata(int_sta_rdata),
      .irq(irq)
   );

   // {rx threshold, bytes pushed, expected receive-ready flag}
   localparam logic [16:0] RXRDY_VEC [8] = '{
      {8'd4,   8'd3,   1'b0},
      {8'd4,   8'd4,   1'b1},
      {8'd4,   8'd5,   1'b1},
      {8'd0,   8'd0,   1'b1},
      {8'd1,   8'd0,   1'b0},
      {8'd96,  8'd95,  1'b0},
      {8'd96,  8'd96,  1'b1},
      {8'd128, 8'd128, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [31:0] v);
      fifo_ctl_we = 1'b1; fifo_ctl_wdata = v;
      @(negedge clk);
      fifo_ctl_we = 1'b0; fifo_ctl_wdata = '0;
   endtask

   task automatic sta_clear(input logic [31:0] v);
      int_sta_we = 1'b1; int_sta_wdata = v;
      @(negedge clk);
      int_sta_we = 1'b0; int_sta_wdata = '0;
   endtask

   task automatic en_write(input logic [31:0] v);
      int_en_we = 1'b1; int_en_wdata = v;
      @(negedge clk);
      int_en_we = 1'b0; int_en_wdata = '0;
   endtask

   task automatic eng_push(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_data = b;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic host_push(input logic [7:0] b);
      host_tx_push = 1'b1; host_tx_data = b;
      @(negedge clk);
      host_tx_push = 1'b0;
   endtask

   task automatic host_pop();
      host_rx_pop = 1'b1;
      @(negedge clk);
      host_rx_pop = 1'b0;
   endtask

   task automatic eng_pop();
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic done_pulse();
      eng_xfer_done = 1'b1;
      @(negedge clk);
      eng_xfer_done = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int errs;
      repeat (4) @(negedge clk);
      // R9: reset values
      chk("R9 ctl reset", fifo_ctl_rdata, 32'h0060_0060);
      rst_n = 1'b1;
      chk("R9 sta reset", fifo_sta_rdata, 32'h0);
      chk("R9 flags reset", int_sta_rdata, 32'h0);
      chk("R9 en reset", int_en_rdata, 32'h0);
      chk("R10 irq reset", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R5 empty tx requests", int_sta_rdata, 32'h10);

      // R4: threshold table
      for (int v = 0; v < 8; v++) begin
         ctl_write({8'h00, 8'd96, 8'h80, RXRDY_VEC[v][16:9]});
         sta_clear(32'h1);
         for (int k = 0; k < int'(RXRDY_VEC[v][8:1]); k++) eng_push(8'(k));
         @(negedge clk);
         chk($sformatf("R4 vec%0d flag", v), {31'b0, int_sta_rdata[0]}, {31'b0, RXRDY_VEC[v][0]});
         chk($sformatf("R1 vec%0d count", v), fifo_sta_rdata[7:0], {24'b0, RXRDY_VEC[v][8:1]});
      end

      // R1: receive ordering
      ctl_write(32'h0060_8060);
      for (int k = 0; k < 5; k++) eng_push(8'(k * 17) ^ 8'hA5);
      chk("R1 rx count", fifo_sta_rdata, 32'h0000_0005);
      for (int k = 0; k < 5; k++) begin
         chk("R1 rx order", {24'b0, host_rx_data}, {24'b0, 8'(k * 17) ^ 8'hA5});
         host_pop();
      end
      chk("R1 rx empty", {31'b0, host_rx_empty}, 32'h1);

      // R1: transmit ordering
      ctl_write(32'h8060_0060);
      for (int k = 0; k < 3; k++) host_push(8'h30 + 8'(k));
      chk("R1 tx count", fifo_sta_rdata, 32'h0003_0000);
      for (int k = 0; k < 3; k++) begin
         chk("R1 tx order", {24'b0, eng_tx_data}, {24'b0, 8'h30 + 8'(k)});
         eng_pop();
      end

      // R5: transmit request threshold 2
      ctl_write(32'h8002_0060);
      for (int k = 0; k < 3; k++) host_push(8'(k));
      sta_clear(32'h10);
      @(negedge clk);
      chk("R5 above level", {31'b0, int_sta_rdata[4]}, 32'h0);
      eng_pop();
      @(negedge clk);
      chk("R5 at level", {31'b0, int_sta_rdata[4]}, 32'h1);

      // R7: clear then reassert, and zero bits ignored
      sta_clear(32'h10);
      chk("R7 cleared", {31'b0, int_sta_rdata[4]}, 32'h0);
      @(negedge clk);
      chk("R7 reasserted", {31'b0, int_sta_rdata[4]}, 32'h1);
      sta_clear(32'h1000);
      chk("R7 zero bit no effect", {31'b0, int_sta_rdata[4]}, 32'h1);

      // R6: transfer complete
      done_pulse();
      chk("R6 done set", {31'b0, int_sta_rdata[12]}, 32'h1);
      sta_clear(32'h1000);
      chk("R6 done cleared", {31'b0, int_sta_rdata[12]}, 32'h0);
      eng_xfer_done = 1'b1; int_sta_we = 1'b1; int_sta_wdata = 32'h1000;
      @(negedge clk);
      eng_xfer_done = 1'b0; int_sta_we = 1'b0; int_sta_wdata = '0;
      chk("R7 event beats clear", {31'b0, int_sta_rdata[12]}, 32'h1);

      // R10: enable masking
      en_write(32'h1000);
      chk("R10 en readback", int_en_rdata, 32'h1000);
      chk("R10 irq enabled", {31'b0, irq}, 32'h1);
      en_write(32'h0100);
      chk("R10 irq masked", {31'b0, irq}, 32'h0);

      // R3: receive overflow
      ctl_write(32'h0002_8060);
      sta_clear(32'h100);
      for (int k = 0; k < 128; k++) eng_push(8'(k));
      chk("R3 full count", fifo_sta_rdata[15:0], 32'h0080);
      chk("R3 no flag yet", {31'b0, int_sta_rdata[8]}, 32'h0);
      eng_push(8'hEE);
      chk("R3 flag set", {31'b0, int_sta_rdata[8]}, 32'h1);
      chk("R3 count held", fifo_sta_rdata[15:0], 32'h0080);
      chk("R10 irq on overflow", {31'b0, irq}, 32'h1);
      errs = 0;
      for (int k = 0; k < 128; k++) begin
         if (host_rx_data !== 8'(k)) errs++;
         host_pop();
      end
      chk("R3 dropped byte absent", errs, 0);

      // R2: transmit full and empty pop
      ctl_write(32'h8002_0060);
      for (int k = 0; k < 129; k++) host_push(8'(k));
      chk("R2 tx count at depth", fifo_sta_rdata[31:16], 32'h0080);
      chk("R2 tx full", {31'b0, host_tx_full}, 32'h1);
      ctl_write(32'h8002_0060);
      chk("R8 tx flushed", fifo_sta_rdata[31:16], 32'h0);
      chk("R8 flush bits read 0", fifo_ctl_rdata, 32'h0002_0060);
      eng_pop();
      chk("R2 empty pop", fifo_sta_rdata[31:16], 32'h0);
      chk("R2 tx empty", {31'b0, eng_tx_empty}, 32'h1);
      host_push(8'h5A);
      chk("R2 order after empty pop", {24'b0, eng_tx_data}, 32'h5A);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule